// File: doc/BRIEF.md
# Capability-Checked Prefetch Request Filter

This block sits between instruction decode and the cache and turns a prefetch hint into at most one cache-line prefetch request. A hint carries a kind (data read, data write or instruction fetch), a 12-bit immediate, and an authorising capability: a validity tag, a sealed flag, base and top bounds, three permission bits and a current address. The block adds the sign-extended immediate to the capability address and clears the low bits to get the line address. It then checks the encoding and the capability. If every check passes, it places one request in a one-entry holding register that drains over a valid/ready handshake.

A hint that fails any check is discarded without a trap. The block has no exception output and no result. For every discarded hint, a debug output pulses for one cycle with a code that names the first failing check. Hints are taken over their own valid/ready handshake. A hint is accepted only when the holding register is empty or is being drained in the same cycle.

Top module: `cap_prefetch_filter`

## Requirements
- R1: The line address `req_addr` equals (`cap_addr` + sign-extended `hint_imm`) modulo 2^AW, with its low log2(LINE_BYTES) bits cleared. `req_kind` repeats `hint_kind`.
- R2: When any of `hint_imm[4:0]` is nonzero, no request is made and the drop reason is 1.
- R3: When `cap_tag` is 0, no request is made and the drop reason is 2.
- R4: When `cap_sealed` is 1, no request is made and the drop reason is 3.
- R5: A request needs line_start < `cap_top` and line_start + LINE_BYTES > `cap_base`. These are unsigned compares over AW+1 bits, so a top of 2^AW covers the last line of the address space. Overlap by a single byte is enough. Otherwise the drop reason is 4.
- R6: The kind code selects the permission that is needed: 0 (read) needs `cap_perm_r`, 1 (write) needs `cap_perm_w` and 2 (instruction) needs `cap_perm_x`. Kind code 3 is never authorised. A missing permission gives drop reason 5.
- R7: When several checks fail, the reported reason is the lowest code that applies.
- R8: Every accepted hint gives exactly one outcome in the next cycle: either `req_valid` is high with the new request, or `drop_pulse` is high. The block has no exception or trap output.
- R9: `hint_ready` equals NOT `req_valid` OR `req_ready`. While `req_valid` is high and `req_ready` is low, the request stays valid and its address and kind do not change.
- R10: In a cycle where a held request is taken and a new hint is accepted, the new outcome replaces the old one with no gap cycle.
- R11: After reset, `req_valid` and `drop_pulse` are 0, `drop_reason` is 0 and `hint_ready` is 1.
- R12: `drop_pulse` is high only in the cycle after a hint that failed was accepted. It lasts exactly one cycle per failed hint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_valid | input | 1 | Hint offered |
| hint_ready | output | 1 | Hint accepted this cycle if valid |
| hint_kind | input | 2 | 0 read, 1 write, 2 instruction, 3 reserved |
| hint_imm | input | 12 | Signed offset immediate |
| cap_tag | input | 1 | Capability validity tag |
| cap_sealed | input | 1 | Capability sealed flag |
| cap_base | input | AW | Lower bound (inclusive) |
| cap_top | input | AW+1 | Upper bound (exclusive) |
| cap_perm_r | input | 1 | Load permission |
| cap_perm_w | input | 1 | Store permission |
| cap_perm_x | input | 1 | Execute permission |
| cap_addr | input | AW | Capability address |
| req_valid | output | 1 | Prefetch request pending |
| req_ready | input | 1 | Cache takes the request |
| req_addr | output | AW | Line-aligned request address |
| req_kind | output | 2 | Kind of the pending request |
| drop_pulse | output | 1 | One-cycle flag for a discarded hint |
| drop_reason | output | 3 | 0 none, 1 encoding, 2 tag, 3 sealed, 4 bounds, 5 permission |

## Verification
Two things can happen in one clock edge: the held request drains and a new hint enters. The new hint can be one that passes, so it replaces the old request, or one that fails, so the register empties and a drop pulses. To provoke this, the bench first fills the holding register with `req_ready` low and checks that a waiting hint is refused. It then raises `req_ready` while the hint is still offered. On the following cycle it judges the result at the ports: the new line address must appear, or `req_valid` must be low with the matching drop reason.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_INSTR = 2'd2,
        KIND_RSVD  = 2'd3
    } pf_kind_e;

    typedef enum logic [2:0] {
        DROP_NONE   = 3'd0,
        DROP_ENC    = 3'd1,
        DROP_TAG    = 3'd2,
        DROP_SEALED = 3'd3,
        DROP_BOUNDS = 3'd4,
        DROP_PERM   = 3'd5
    } pf_drop_e;

    localparam int unsigned IMM_W    = 12;
    localparam int unsigned ENC_ZERO = 5;

endpackage

// File: rtl/pf_addr_gen.sv
module pf_addr_gen
    import pf_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic [AW-1:0]    base_addr,
    input  logic [IMM_W-1:0] imm,
    output logic [AW-1:0]    line_start,
    output logic [AW:0]      line_end
);
    localparam int unsigned   LINE_LG  = $clog2(LINE_BYTES);
    localparam logic [AW:0]   LINE_EXT = (AW+1)'(LINE_BYTES);

    logic [AW-1:0] imm_ext;
    logic [AW-1:0] eff_addr;

    always_comb begin
        imm_ext    = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
        eff_addr   = base_addr + imm_ext;
        line_start = {eff_addr[AW-1:LINE_LG], {LINE_LG{1'b0}}};
        line_end   = {1'b0, line_start} + LINE_EXT;
    end

endmodule

// File: rtl/pf_auth_check.sv
module pf_auth_check
    import pf_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [IMM_W-1:0] imm,
    input  pf_kind_e         kind,
    input  logic             tag,
    input  logic             sealed,
    input  logic [AW-1:0]    base,
    input  logic [AW:0]      top,
    input  logic             perm_r,
    input  logic             perm_w,
    input  logic             perm_x,
    input  logic [AW-1:0]    line_start,
    input  logic [AW:0]      line_end,
    output pf_drop_e         reason
);
    logic enc_ok;
    logic in_bounds;
    logic perm_ok;

    always_comb begin
        enc_ok    = (imm[ENC_ZERO-1:0] == '0);
        in_bounds = ({1'b0, line_start} < top) && (line_end > {1'b0, base});
        unique case (kind)
            KIND_READ:  perm_ok = perm_r;
            KIND_WRITE: perm_ok = perm_w;
            KIND_INSTR: perm_ok = perm_x;
            default:    perm_ok = 1'b0;
        endcase

        if (!enc_ok)          reason = DROP_ENC;
        else if (!tag)        reason = DROP_TAG;
        else if (sealed)      reason = DROP_SEALED;
        else if (!in_bounds)  reason = DROP_BOUNDS;
        else if (!perm_ok)    reason = DROP_PERM;
        else                  reason = DROP_NONE;
    end

endmodule

// File: rtl/pf_req_slot.sv
module pf_req_slot
    import pf_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  pf_kind_e      load_kind,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output pf_kind_e      out_kind,
    output logic          can_accept
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        pf_kind_e      kind;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d     = slot_q;
        can_accept = !slot_q.valid || out_ready;
        if (slot_q.valid && out_ready) begin
            slot_d.valid = 1'b0;
        end
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.addr  = load_addr;
            slot_d.kind  = load_kind;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '{valid: 1'b0, addr: '0, kind: KIND_READ};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_valid = slot_q.valid;
    assign out_addr  = slot_q.addr;
    assign out_kind  = slot_q.kind;

endmodule

// File: rtl/cap_prefetch_filter.sv
module cap_prefetch_filter
    import pf_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hint_valid,
    output logic          hint_ready,
    input  logic [1:0]    hint_kind,
    input  logic [11:0]   hint_imm,
    input  logic          cap_tag,
    input  logic          cap_sealed,
    input  logic [AW-1:0] cap_base,
    input  logic [AW:0]   cap_top,
    input  logic          cap_perm_r,
    input  logic          cap_perm_w,
    input  logic          cap_perm_x,
    input  logic [AW-1:0] cap_addr,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] req_addr,
    output logic [1:0]    req_kind,
    output logic          drop_pulse,
    output logic [2:0]    drop_reason
);
    typedef struct packed {
        logic     pulse;
        pf_drop_e reason;
    } drop_t;

    logic [AW-1:0] line_start;
    logic [AW:0]   line_end;
    pf_drop_e      reason;
    pf_kind_e      kind_in;
    pf_kind_e      kind_out;
    logic          accept;
    logic          load;
    logic          slot_free;
    drop_t         drop_d, drop_q;

    assign kind_in = pf_kind_e'(hint_kind);

    pf_addr_gen #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_addr (
        .base_addr (cap_addr),
        .imm       (hint_imm),
        .line_start(line_start),
        .line_end  (line_end)
    );

    pf_auth_check #(.AW(AW)) u_auth (
        .imm       (hint_imm),
        .kind      (kind_in),
        .tag       (cap_tag),
        .sealed    (cap_sealed),
        .base      (cap_base),
        .top       (cap_top),
        .perm_r    (cap_perm_r),
        .perm_w    (cap_perm_w),
        .perm_x    (cap_perm_x),
        .line_start(line_start),
        .line_end  (line_end),
        .reason    (reason)
    );

    always_comb begin
        accept = hint_valid && slot_free;
        load   = accept && (reason == DROP_NONE);
        drop_d = '{pulse: 1'b0, reason: DROP_NONE};
        if (accept && (reason != DROP_NONE)) begin
            drop_d.pulse  = 1'b1;
            drop_d.reason = reason;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= '{pulse: 1'b0, reason: DROP_NONE};
        end else begin
            drop_q <= drop_d;
        end
    end

    pf_req_slot #(.AW(AW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (line_start),
        .load_kind (kind_in),
        .out_ready (req_ready),
        .out_valid (req_valid),
        .out_addr  (req_addr),
        .out_kind  (kind_out),
        .can_accept(slot_free)
    );

    assign hint_ready  = slot_free;
    assign req_kind    = kind_out;
    assign drop_pulse  = drop_q.pulse;
    assign drop_reason = drop_q.reason;

endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter int unsigned AW         = 32,
    parameter int unsigned LINE_BYTES = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hint_valid,
    input logic          hint_ready,
    input logic [11:0]   hint_imm,
    input logic          cap_tag,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [1:0]    req_kind,
    input logic          drop_pulse,
    input logic [2:0]    drop_reason
);
    localparam int unsigned LINE_LG = $clog2(LINE_BYTES);

    // R8: an accepted hint yields a request or a drop, never both
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_valid && hint_ready) |=> (drop_pulse ^ req_valid));

    // R12: no drop pulse without an accepted hint the cycle before
    a_r12_drop_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !(hint_valid && hint_ready) |=> !drop_pulse);

    // R9: a stalled request holds its contents
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_kind)));

    // R2: a bad encoding is dropped with reason 1
    a_r2_enc_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_valid && hint_ready && (hint_imm[4:0] != 5'd0)) |=> (drop_pulse && drop_reason == 3'd1));

    // R3: a clear tag with a valid encoding is dropped with reason 2
    a_r3_tag_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_valid && hint_ready && (hint_imm[4:0] == 5'd0) && !cap_tag) |=> (drop_pulse && drop_reason == 3'd2));

    // R1: requests are always line aligned
    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[LINE_LG-1:0] == '0));

    // R12: a quiet cycle reports reason zero
    a_r12_reason_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_pulse |-> (drop_reason == 3'd0));

endmodule

bind cap_prefetch_filter pf_checker #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_pf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .hint_valid (hint_valid),
    .hint_ready (hint_ready),
    .hint_imm   (hint_imm),
    .cap_tag    (cap_tag),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_kind   (req_kind),
    .drop_pulse (drop_pulse),
    .drop_reason(drop_reason)
);

// File: tb/test_cap_prefetch_filter.sv
`timescale 1ns/1ps
module test_cap_prefetch_filter;
    localparam int AW   = 12;
    localparam int LINE = 32;
    localparam int SPACE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hint_valid = 1'b0;
    logic          hint_ready;
    logic [1:0]    hint_kind = '0;
    logic [11:0]   hint_imm = '0;
    logic          cap_tag = 1'b0;
    logic          cap_sealed = 1'b0;
    logic [AW-1:0] cap_base = '0;
    logic [AW:0]   cap_top = '0;
    logic          cap_perm_r = 1'b0;
    logic          cap_perm_w = 1'b0;
    logic          cap_perm_x = 1'b0;
    logic [AW-1:0] cap_addr = '0;
    logic          req_valid;
    logic          req_ready = 1'b1;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_kind;
    logic          drop_pulse;
    logic [2:0]    drop_reason;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    cap_prefetch_filter #(.AW(AW), .LINE_BYTES(LINE)) i_cap_prefetch_filter (
        .clk(clk), .rst_n(rst_n),
        .hint_valid(hint_valid), .hint_ready(hint_ready),
        .hint_kind(hint_kind), .hint_imm(hint_imm),
        .cap_tag(cap_tag), .cap_sealed(cap_sealed),
        .cap_base(cap_base), .cap_top(cap_top),
        .cap_perm_r(cap_perm_r), .cap_perm_w(cap_perm_w), .cap_perm_x(cap_perm_x),
        .cap_addr(cap_addr),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind),
        .drop_pulse(drop_pulse), .drop_reason(drop_reason)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int r);
        case (r)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R1";
        endcase
    endfunction

    // Independent model: returns reason code, sets expected line address
    function automatic int model(input int kind, input int imm, input int tag,
                                 input int sealed, input int base, input int top,
                                 input int perms, input int addr, output int line);
        int simm, ea, le;
        simm = (imm >= 2048) ? imm - 4096 : imm;
        ea   = ((addr + simm) % SPACE + SPACE) % SPACE;
        line = ea - (ea % LINE);
        le   = line + LINE;
        if ((imm % 32) != 0) return 1;
        if (tag == 0) return 2;
        if (sealed != 0) return 3;
        if (!(line < top && le > base)) return 4;
        if (kind == 3) return 5;
        if (((perms >> kind) & 1) == 0) return 5;
        return 0;
    endfunction

    task automatic drive(input int kind, input int imm, input int tag, input int sealed,
                         input int base, input int top, input int perms, input int addr);
        hint_kind  = 2'(kind);
        hint_imm   = 12'(imm);
        cap_tag    = tag[0];
        cap_sealed = sealed[0];
        cap_base   = AW'(base);
        cap_top    = (AW+1)'(top);
        cap_perm_r = perms[0];
        cap_perm_w = perms[1];
        cap_perm_x = perms[2];
        cap_addr   = AW'(addr);
    endtask

    // One hint with the output side always ready
    task automatic one_hint(input int kind, input int imm, input int tag, input int sealed,
                            input int base, input int top, input int perms, input int addr);
        int exp_r, exp_line;
        string rq;
        exp_r = model(kind, imm, tag, sealed, base, top, perms, addr, exp_line);
        rq = req_of(exp_r);
        @(negedge clk);
        drive(kind, imm, tag, sealed, base, top, perms, addr);
        hint_valid = 1'b1;
        @(negedge clk);
        hint_valid = 1'b0;
        if (exp_r == 0) begin
            chk(req_valid && !drop_pulse && req_addr == AW'(exp_line) && req_kind == 2'(kind),
                "R1", "request line address", int'(req_addr), exp_line);
        end else begin
            // R7 (lowest code wins) is covered by the model's order
            chk(drop_pulse && !req_valid && drop_reason == 3'(exp_r),
                rq, "drop reason (R7 priority)", int'(drop_reason), exp_r);
        end
        @(negedge clk);
        chk(!drop_pulse && !req_valid, "R12", "single-cycle outcome",
            int'({drop_pulse, req_valid}), 0);
    endtask

    // Bounds scenarios: addr, base, top
    function automatic void bcase(input int i, output int addr, output int base, output int top);
        case (i)
            0: begin addr = 'h105; base = 'h11F; top = 'h200;  end // one-byte overlap at end
            1: begin addr = 'h105; base = 'h120; top = 'h200;  end // just below base
            2: begin addr = 'h105; base = 'h000; top = 'h101;  end // one byte at start
            3: begin addr = 'h105; base = 'h000; top = 'h100;  end // top equals line start
            4: begin addr = 'hFF8; base = 'hF00; top = 'h1000; end // last line of space
            default: begin addr = 'h010; base = 'hFC0; top = 'h1000; end // wraps with negative imm
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int a, b, t;
        int imms [3] = '{'h000, 'hFE0, 'h005};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(!req_valid && !drop_pulse && drop_reason == 0 && hint_ready, "R11", "reset outputs",
            int'({req_valid, drop_pulse, drop_reason, hint_ready}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid && !drop_pulse && hint_ready, "R11", "after reset release",
            int'({req_valid, drop_pulse, hint_ready}), 1);

        // Sweep: R1..R7, R12
        for (int bc = 0; bc < 6; bc++)
            for (int ic = 0; ic < 3; ic++)
                for (int k = 0; k < 4; k++)
                    for (int tg = 0; tg < 2; tg++)
                        for (int sl = 0; sl < 2; sl++)
                            for (int p = 0; p < 8; p++) begin
                                bcase(bc, a, b, t);
                                one_hint(k, imms[ic], tg, sl, b, t, p, a);
                            end

        // R9 / R10: backpressure, then drain and accept in one edge
        @(negedge clk);
        req_ready = 1'b0;
        drive(0, 0, 1, 0, 0, 'h1000, 7, 'h105);
        hint_valid = 1'b1;
        @(negedge clk);
        drive(1, 0, 1, 0, 0, 'h1000, 7, 'h345);
        chk(!hint_ready, "R9", "ready low while full", int'(hint_ready), 0);
        @(negedge clk);
        chk(req_valid && req_addr == 12'h100 && req_kind == 2'd0 && !drop_pulse,
            "R9", "held request stable", int'(req_addr), 'h100);
        req_ready = 1'b1;
        #1;
        chk(hint_ready, "R9", "ready follows req_ready", int'(hint_ready), 1);
        @(negedge clk);
        hint_valid = 1'b0;
        chk(req_valid && req_addr == 12'h340 && req_kind == 2'd1 && !drop_pulse,
            "R10", "replacement request", int'(req_addr), 'h340);
        req_ready = 1'b0;
        drive(2, 0, 0, 0, 0, 'h1000, 7, 'h500);
        hint_valid = 1'b1;
        @(negedge clk);
        chk(!drop_pulse && req_valid && req_addr == 12'h340, "R9", "failing hint waits",
            int'(drop_pulse), 0);
        req_ready = 1'b1;
        @(negedge clk);
        hint_valid = 1'b0;
        chk(!req_valid && drop_pulse && drop_reason == 3'd2, "R10", "drain plus drop",
            int'(drop_reason), 2);
        chk(!(req_valid && drop_pulse), "R8", "single outcome", int'({req_valid, drop_pulse}), 1);
        @(negedge clk);
        chk(!drop_pulse && !req_valid && hint_ready, "R12", "quiet after drop",
            int'({drop_pulse, req_valid}), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule